// File: doc/BRIEF.md
# Masked Interrupt Flag Register

This block collects the interrupt causes of a card-interface controller into one flag register, pairs it with a per-source mask register and drives a single interrupt line toward the processor. Four causes are event pulses: data transfer done, programming done, end of command response and card interrupt. Each pulse sets a sticky flag. Software clears a sticky flag by writing a one to its bit.

The receive-service and transmit-service requests are levels. Their flag bits always show the current FIFO condition, and software writes do not change them. A mask bit of one keeps its source away from the interrupt line. The line is the registered OR of every flag whose mask bit is zero.

Both registers are reached through a simple valid / write / address / write-data bus. Read data returns on the cycle after the read request and holds until the next read.

Top module: `mif_irq_ctrl`

## Requirements
- R1: Event pulses set sticky flags at these flag-register positions: bit 0 data transfer done, bit 1 programming done, bit 2 end of command response, bit 7 card interrupt. A pulse sampled at one clock edge is visible in a read request issued on any later cycle.
- R2: A write to the flag register at offset 0x28 clears every sticky flag whose write-data bit is 1. Sticky flags whose write-data bit is 0 are unchanged, and without an event or a clearing write a sticky flag holds its value.
- R3: When an event pulse and a clearing write reach the same sticky flag in the same cycle, the flag ends up set.
- R4: Flag bit 5 equals the receive-request input and flag bit 6 equals the transmit-request input on the cycle of the read. Writes to the flag register do not affect these two bits.
- R5: The 16-bit mask register sits at offset 0x24, resets to 0xFFFF and reads back the last value written.
- R6: The interrupt output is a register. After each clock edge it equals the OR over all bits of (flag & ~mask), using the flag and mask values present before that edge.
- R7: Flag-register bits 3, 4 and 8 to 15 always read zero. A read from any offset other than 0x24 or 0x28 returns zero, and a write to such an offset changes no register.
- R8: After reset all sticky flags are clear, the interrupt output is low and the read data is zero.
- R9: Read data is registered. It updates only on a read request, at the clock edge that samples the request, and holds its value across all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read request |
| ev_data_done | input | 1 | Pulse: data transfer finished |
| ev_prog_done | input | 1 | Pulse: card programming finished |
| ev_resp_end | input | 1 | Pulse: command response received |
| ev_card_irq | input | 1 | Pulse: card raised an interrupt |
| rx_fifo_req | input | 1 | Level: receive FIFO needs service |
| tx_fifo_req | input | 1 | Level: transmit FIFO needs service |
| irq | output | 1 | Interrupt request to the processor |

## Verification
If a sticky flag is lost or held wrongly, it shows up in the next flag read one cycle after the read request. It also shows up on the interrupt line one cycle after the edge once the mask bit for that flag is opened. A mask or level-path error moves the interrupt line on the first edge after the offending input, so the bench compares the line on every cycle against a reference model. Same-cycle set and clear collisions, writes to level bits and unmapped offsets are driven on purpose as well as by random traffic, so that each defect is caught by a read-back within one or two cycles.

// File: rtl/mif_irq_pkg.sv
package mif_irq_pkg;

    localparam int          REG_WIDTH     = 16;
    localparam int          ADDR_WIDTH    = 8;
    localparam logic [7:0]  OFS_FLAG      = 8'h28;
    localparam logic [7:0]  OFS_MASK      = 8'h24;

    // Flag bit positions (decoded by software)
    localparam int          BIT_XFER_DONE = 0;
    localparam int          BIT_PROG_DONE = 1;
    localparam int          BIT_RESP_END  = 2;
    localparam int          BIT_RX_REQ    = 5;
    localparam int          BIT_TX_REQ    = 6;
    localparam int          BIT_CARD_IRQ  = 7;

    typedef struct packed {
        logic flag_wr;
        logic mask_wr;
        logic rd_flag;
        logic rd_mask;
        logic rd_any;
    } bus_dec_t;

endpackage

// File: rtl/mif_bus_dec.sv
module mif_bus_dec
    import mif_irq_pkg::*;
#(
    parameter int                ADDR_W   = ADDR_WIDTH,
    parameter logic [ADDR_W-1:0] FLAG_ADR = ADDR_W'(OFS_FLAG),
    parameter logic [ADDR_W-1:0] MASK_ADR = ADDR_W'(OFS_MASK)
) (
    input  logic              valid_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    output bus_dec_t          dec_o
);
    logic hit_flag;
    logic hit_mask;

    always_comb begin
        hit_flag      = (addr_i == FLAG_ADR);
        hit_mask      = (addr_i == MASK_ADR);
        dec_o.flag_wr = valid_i &  write_i & hit_flag;
        dec_o.mask_wr = valid_i &  write_i & hit_mask;
        dec_o.rd_flag = valid_i & ~write_i & hit_flag;
        dec_o.rd_mask = valid_i & ~write_i & hit_mask;
        dec_o.rd_any  = valid_i & ~write_i;
    end
endmodule

// File: rtl/mif_flag_bank.sv
module mif_flag_bank #(
    parameter int             W        = 16,
    parameter logic [W-1:0]   IMPL_MSK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flag_o
);
    logic [W-1:0] flag_d;
    logic [W-1:0] flag_q;

    // set has priority over a same-cycle clear
    always_comb begin
        flag_d = ((flag_q & ~clr_i) | set_i) & IMPL_MSK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    for (genvar i = 0; i < W; i++) begin : g_chk
        if (IMPL_MSK[i]) begin : g_impl
            AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
                set_i[i] |=> flag_o[i]);                                   // R3
            AST_ONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[i] && !set_i[i]) |=> !flag_o[i]);                   // R2
            AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr_i[i] && !set_i[i]) |=> $stable(flag_o[i]));          // R2
        end
    end
endmodule

// File: rtl/mif_irq_ctrl.sv
module mif_irq_ctrl
    import mif_irq_pkg::*;
#(
    parameter int                REG_W    = REG_WIDTH,
    parameter int                ADDR_W   = ADDR_WIDTH,
    parameter logic [ADDR_W-1:0] FLAG_ADR = ADDR_W'(OFS_FLAG),
    parameter logic [ADDR_W-1:0] MASK_ADR = ADDR_W'(OFS_MASK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              ev_data_done,
    input  logic              ev_prog_done,
    input  logic              ev_resp_end,
    input  logic              ev_card_irq,
    input  logic              rx_fifo_req,
    input  logic              tx_fifo_req,
    output logic              irq
);
    localparam logic [REG_W-1:0] EDGE_MSK = REG_W'((1 << BIT_XFER_DONE) | (1 << BIT_PROG_DONE) |
                                                   (1 << BIT_RESP_END)  | (1 << BIT_CARD_IRQ));
    localparam logic [REG_W-1:0] LVL_MSK  = REG_W'((1 << BIT_RX_REQ) | (1 << BIT_TX_REQ));
    localparam logic [REG_W-1:0] DEF_MSK  = EDGE_MSK | LVL_MSK;

    typedef struct packed {
        logic [REG_W-1:0] mask;
        logic [REG_W-1:0] rdata;
        logic             irq;
    } state_t;

    state_t           st_d;
    state_t           st_q;
    bus_dec_t         dec;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] lvl_vec;
    logic [REG_W-1:0] sticky;
    logic [REG_W-1:0] flag_view;

    mif_bus_dec #(
        .ADDR_W   (ADDR_W),
        .FLAG_ADR (FLAG_ADR),
        .MASK_ADR (MASK_ADR)
    ) dec_i (
        .valid_i (bus_valid),
        .write_i (bus_write),
        .addr_i  (bus_addr),
        .dec_o   (dec)
    );

    always_comb begin
        set_vec                = '0;
        set_vec[BIT_XFER_DONE] = ev_data_done;
        set_vec[BIT_PROG_DONE] = ev_prog_done;
        set_vec[BIT_RESP_END]  = ev_resp_end;
        set_vec[BIT_CARD_IRQ]  = ev_card_irq;
        lvl_vec                = '0;
        lvl_vec[BIT_RX_REQ]    = rx_fifo_req;
        lvl_vec[BIT_TX_REQ]    = tx_fifo_req;
        clr_vec                = dec.flag_wr ? (bus_wdata & EDGE_MSK) : '0;
    end

    mif_flag_bank #(
        .W        (REG_W),
        .IMPL_MSK (EDGE_MSK)
    ) bank_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .flag_o (sticky)
    );

    always_comb begin
        flag_view = sticky | lvl_vec;
        st_d      = st_q;
        st_d.irq  = |(flag_view & ~st_q.mask);
        if (dec.mask_wr) st_d.mask = bus_wdata;
        if (dec.rd_any) begin
            if (dec.rd_flag)      st_d.rdata = flag_view;
            else if (dec.rd_mask) st_d.rdata = st_q.mask;
            else                  st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mask  <= '1;
            st_q.rdata <= '0;
            st_q.irq   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign irq       = st_q.irq;

    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&st_q.mask) |=> !irq);                                            // R6
    AST_RX_OPEN_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fifo_req && !st_q.mask[BIT_RX_REQ]) |=> irq);                  // R6
    AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        dec.rd_flag |=> ((bus_rdata & ~DEF_MSK) == '0));                   // R7
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !dec.rd_any |=> $stable(bus_rdata));                               // R9
endmodule

// File: tb/mif_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module mif_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_valid, bus_write;
    logic [7:0]  bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic        ev_data_done, ev_prog_done, ev_resp_end, ev_card_irq;
    logic        rx_fifo_req, tx_fifo_req, irq;

    always #2 clk = ~clk;

    mif_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_data_done(ev_data_done), .ev_prog_done(ev_prog_done),
        .ev_resp_end(ev_resp_end), .ev_card_irq(ev_card_irq),
        .rx_fifo_req(rx_fifo_req), .tx_fifo_req(tx_fifo_req), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] m_flag = '0, m_mask = 16'hFFFF, m_rdata = '0;
    logic        m_irq = 1'b0;
    logic        m_rx = 1'b0, m_tx = 1'b0;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ev_to_bits(input logic [3:0] ev);
        logic [15:0] s = '0;
        s[0] = ev[0]; s[1] = ev[1]; s[2] = ev[2]; s[7] = ev[3];
        return s;
    endfunction

    function automatic logic [15:0] view(input logic [15:0] f, input logic rx, input logic tx);
        return f | (16'(rx) << 5) | (16'(tx) << 6);
    endfunction

    // one clock: drive at negedge, model the edge, compare at next negedge
    task automatic cyc(input logic [3:0] ev, input logic rx, input logic tx,
                       input logic v, input logic w, input logic [7:0] a,
                       input logic [15:0] wd, input string tag);
        logic [15:0] vw;
        {ev_card_irq, ev_resp_end, ev_prog_done, ev_data_done} = ev;
        rx_fifo_req = rx; tx_fifo_req = tx;
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = wd;
        vw    = view(m_flag, rx, tx);
        m_irq = |(vw & ~m_mask);
        if (v && !w) m_rdata = (a == 8'h28) ? vw : (a == 8'h24) ? m_mask : 16'h0;
        m_flag = (m_flag & ~((v && w && a == 8'h28) ? (wd & 16'h0087) : 16'h0)) | ev_to_bits(ev);
        if (v && w && a == 8'h24) m_mask = wd;
        m_rx = rx; m_tx = tx;
        @(posedge clk);
        @(negedge clk);
        chk("R6 irq", {15'b0, irq}, {15'b0, m_irq});
        chk({tag, " rdata"}, bus_rdata, m_rdata);
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        cyc(4'b0, m_rx, m_tx, 1'b1, 1'b0, a, 16'h0, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d, input string tag);
        cyc(4'b0, m_rx, m_tx, 1'b1, 1'b1, a, d, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        {ev_card_irq, ev_resp_end, ev_prog_done, ev_data_done} = '0;
        rx_fifo_req = 0; tx_fifo_req = 0;
        bus_valid = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        chk("R8 irq after reset", {15'b0, irq}, 16'h0);
        chk("R8 rdata after reset", bus_rdata, 16'h0);
        rst_n = 1'b1;
        rd(8'h28, "R8 flags clear");
        rd(8'h24, "R5 mask reset");

        // R1: each event sets its own bit; mask still closed so irq stays low
        for (int i = 0; i < 4; i++) begin
            cyc(4'(1 << i), 0, 0, 0, 0, 8'h0, 16'h0, "R1 pulse");
            rd(8'h28, "R1 flag set");
        end
        // R2: zero write keeps, one write clears
        wr(8'h28, 16'h0000, "R2 zero write");
        rd(8'h28, "R2 zero keeps");
        wr(8'h28, 16'h0005, "R2 one write");
        rd(8'h28, "R2 ones clear");
        // R3: collision of set and clear on bit 1 and bit 0
        wr(8'h28, 16'h0087, "R3 clear all");
        cyc(4'b0011, 0, 0, 1, 1, 8'h28, 16'h0003, "R3 collide");
        rd(8'h28, "R3 set wins");
        // R4: level bits follow inputs, ignore clears
        cyc(4'b0, 1, 1, 0, 0, 8'h0, 16'h0, "R4 raise");
        wr(8'h28, 16'h0060, "R4 clear try");
        rd(8'h28, "R4 level kept");
        cyc(4'b0, 1, 0, 1, 0, 8'h28, 16'h0, "R4 tx drop");
        cyc(4'b0, 0, 0, 1, 0, 8'h28, 16'h0, "R4 rx drop");
        // R5/R6: open masks and watch irq
        wr(8'h24, 16'hFFDF, "R5 open rx");
        rd(8'h24, "R5 mask readback");
        cyc(4'b0, 1, 0, 0, 0, 8'h0, 16'h0, "R6 rx fires");
        cyc(4'b0, 0, 0, 0, 0, 8'h0, 16'h0, "R6 rx drops");
        wr(8'h24, 16'hFF7F, "R6 open card");
        wr(8'h28, 16'h0087, "R6 clear");
        cyc(4'b1000, 0, 0, 0, 0, 8'h0, 16'h0, "R6 card pulse");
        wr(8'h28, 16'h0080, "R6 card ack");
        // R7: undefined bits, unmapped offsets
        wr(8'h24, 16'h0000, "R7 open all");
        cyc(4'b1111, 1, 1, 1, 1, 8'h30, 16'hFFFF, "R7 unmapped write");
        rd(8'h28, "R7 undefined zero");
        rd(8'h24, "R7 mask untouched");
        rd(8'h00, "R7 unmapped read");
        // R9: holds without a read
        cyc(4'b0, 0, 0, 1, 1, 8'h28, 16'hFFFF, "R9 hold on write");
        cyc(4'b0, 0, 0, 0, 0, 8'h0, 16'h0, "R9 hold idle");

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [3:0]  ev;
            logic [7:0]  a;
            logic [31:0] r;
            r  = $urandom;
            ev = ((r[3:0] & r[7:4] & r[11:8]));
            case (r[13:12])
                2'd0:    a = 8'h24;
                2'd3:    a = 8'($urandom);
                default: a = 8'h28;
            endcase
            cyc(ev, r[14] & r[15], r[16] & r[17], r[18], r[19], a,
                16'($urandom) | (a == 8'h24 ? 16'(r[21:20]) << 14 : 16'h0), "R1 R2 R4 R9 random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule